// File: doc/BRIEF.md
# Adaptive Vertical Luma Enhancer

This block sharpens horizontal edges in the picture, that is, transitions between vertically adjacent lines, in an 8-bit luminance sample stream. It keeps two line delays, so every output sample can see the current line, the line before it and the line before that. From these three samples it forms a vertical high-pass detail term. A programmable noise slice (coring) removes small detail. Positive detail, which lifts towards white, and negative detail, which pushes towards black, each have their own 4-bit gain. The scaled detail is added back to the centre-line sample and the sum is clipped to the 8-bit range.

Samples whose centre-line value is below a fixed sync threshold pass through unchanged, so blanking and sync tips are never enhanced. An active-low enable pin switches enhancement on. The bypass value travels through the same pipeline as the enhanced value, so turning enhancement on or off does not shift the picture. A clock enable marks valid samples. A select input chooses one of two line lengths for the line delays. The recommended level settings are 6 for the noise slice, 10 for white gain and 11 for black gain.

Top module: `vert_luma_enh`

## Requirements
- R1: With top = the sample presented now, mid = the sample presented one line earlier and bot = the sample two lines earlier, the detail is hp = floor((2*mid - top - bot)/4). The line length is LEN_SHORT samples when line_sel_i is 0 and LEN_LONG samples when line_sel_i is 1.
- R2: When |hp| is below core_lvl_i (0..15), the detail is forced to 0. A core level of 0 lets all detail through.
- R3: Positive detail adds floor(hp*white_lvl_i/8) to mid. A white level of 0 adds nothing and a level of 8 is unity gain.
- R4: Negative detail adds floor(hp*black_lvl_i/8) to mid, rounding towards minus infinity.
- R5: The sum of mid and the scaled detail is clipped to the range 0..255.
- R6: While enh_off_i is 1, the output equals mid without modification.
- R7: When mid is below SYNC_TH (default 16), the output equals mid whatever the detail. A mid equal to SYNC_TH is enhanced normally.
- R8: A sample accepted at clock-enabled edge k reaches luma_o after edge k+3 (4 clocks) on both the bypass path and the enhanced path. The enh_off_i value sampled at edge k governs that same sample.
- R9: While ce_i is 0, the block does not advance, luma_o holds its value and luma_i is ignored.
- R10: While rst_ni is low, luma_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_i | input | 1 | Clock enable, 1 for a valid sample |
| line_sel_i | input | 1 | Line length select: 0 short, 1 long |
| luma_i | input | 8 | Luminance sample in |
| enh_off_i | input | 1 | 1 disables enhancement (active-low enable) |
| core_lvl_i | input | 4 | Noise slice level |
| white_lvl_i | input | 4 | Gain for positive detail, in eighths |
| black_lvl_i | input | 4 | Gain for negative detail, in eighths |
| luma_o | output | 8 | Enhanced luminance out |

## Verification
The bench builds the block with LEN_SHORT=4 and LEN_LONG=7, and keeps SYNC_TH at its default of 16. With lines this short, a full three-line history of flat lines fills in a dozen or so samples. This makes it cheap to cover each gain, the coring edge, clipping at both rails and the sync threshold boundary at 15 and 16, and it lets both line length selections be exercised in the same run. The enable toggle is placed within a single line so that the exact 4-clock switchover can be observed.

// File: rtl/vle_pkg.sv
package vle_pkg;
  localparam int PIX_W     = 8;
  localparam int LVL_W     = 4;
  localparam int DET_SHIFT = 2;                // detail = (2m - t - b) / 4
  localparam int GAIN_FRAC = 3;                // gain in eighths
  localparam int RAW_W     = PIX_W + 3;
  localparam int DET_W     = PIX_W + 1;
  localparam int PROD_W    = DET_W + LVL_W + 1;
  localparam int ADJ_W     = PROD_W - GAIN_FRAC;
  localparam int SUM_W     = ADJ_W + 1;

  typedef logic [PIX_W-1:0]        pix_t;
  typedef logic [LVL_W-1:0]        lvl_t;
  typedef logic signed [DET_W-1:0] det_t;
  typedef logic signed [ADJ_W-1:0] adj_t;

  function automatic pix_t clip_pix(input logic signed [SUM_W-1:0] v);
    if (v[SUM_W-1]) return '0;
    else if (|v[SUM_W-2:PIX_W]) return '1;
    else return v[PIX_W-1:0];
  endfunction
endpackage

// File: rtl/vle_line_mem.sv
module vle_line_mem #(
  parameter int DEPTH = 1135,
  parameter int W     = 8,
  parameter int AW    = 11
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [DEPTH];

  // read-before-write: the read returns the value stored one line ago
  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/vle_detail.sv
module vle_detail
  import vle_pkg::*;
#(
  parameter int SYNC_TH = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_i,
  input  pix_t top_i,
  input  pix_t mid_i,
  input  pix_t bot_i,
  input  lvl_t core_i,
  input  logic off_i,
  output det_t det_o,
  output pix_t mid_o,
  output logic byp_o
);
  localparam pix_t SYNC_C = PIX_W'(SYNC_TH);

  logic signed [RAW_W-1:0] raw, raw_sh;
  det_t                    hp;
  logic [DET_W-1:0]        mag;
  logic                    kill, sync;

  always_comb begin
    raw    = $signed({2'b00, mid_i, 1'b0}) - $signed({3'b000, top_i})
           - $signed({3'b000, bot_i});
    raw_sh = raw >>> DET_SHIFT;
    hp     = raw_sh[DET_W-1:0];
    mag    = hp[DET_W-1] ? DET_W'(-hp) : DET_W'(hp);
    kill   = mag < {{(DET_W-LVL_W){1'b0}}, core_i};
    sync   = mid_i < SYNC_C;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      det_o <= '0;
      mid_o <= '0;
      byp_o <= 1'b0;
    end else if (ce_i) begin
      det_o <= kill ? '0 : hp;
      mid_o <= mid_i;
      byp_o <= off_i | sync;
    end
  end

  AST_CORE_KILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && kill) |=> (det_o == '0)); // R2
  AST_SYNC_BYP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && (mid_i < SYNC_C)) |=> byp_o); // R7
endmodule

// File: rtl/vle_gain.sv
module vle_gain
  import vle_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_i,
  input  det_t det_i,
  input  pix_t mid_i,
  input  logic byp_i,
  input  lvl_t white_i,
  input  lvl_t black_i,
  output pix_t luma_o
);
  lvl_t                     sel;
  logic signed [PROD_W-1:0] prod, prod_sh;
  adj_t                     adj_d, adj_q;
  pix_t                     mid_q;
  logic                     byp_q;
  logic signed [SUM_W-1:0]  sum;

  always_comb begin
    sel     = det_i[DET_W-1] ? black_i : white_i;
    prod    = det_i * $signed({1'b0, sel});
    prod_sh = prod >>> GAIN_FRAC;
    adj_d   = prod_sh[ADJ_W-1:0];
    sum     = $signed({{(SUM_W-PIX_W){1'b0}}, mid_q}) + $signed({adj_q[ADJ_W-1], adj_q});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      adj_q  <= '0;
      mid_q  <= '0;
      byp_q  <= 1'b0;
      luma_o <= '0;
    end else if (ce_i) begin
      adj_q  <= adj_d;
      mid_q  <= mid_i;
      byp_q  <= byp_i;
      luma_o <= byp_q ? mid_q : clip_pix(sum);
    end
  end

  AST_BYPASS_EXACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && byp_q) |=> (luma_o == $past(mid_q))); // R6
  AST_WHITE_NO_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && !byp_q && !adj_q[ADJ_W-1]) |=> (luma_o >= $past(mid_q))); // R3
  AST_BLACK_NO_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && !byp_q && adj_q[ADJ_W-1]) |=> (luma_o <= $past(mid_q))); // R4
  AST_CE_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_i |=> $stable(luma_o)); // R9
endmodule

// File: rtl/vert_luma_enh.sv
module vert_luma_enh
  import vle_pkg::*;
#(
  parameter int LEN_SHORT = 910,
  parameter int LEN_LONG  = 1135,
  parameter int SYNC_TH   = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ce_i,
  input  logic       line_sel_i,
  input  logic [7:0] luma_i,
  input  logic       enh_off_i,
  input  logic [3:0] core_lvl_i,
  input  logic [3:0] white_lvl_i,
  input  logic [3:0] black_lvl_i,
  output logic [7:0] luma_o
);
  localparam int N_LINES = 2;
  localparam int LEN_MAX = (LEN_LONG > LEN_SHORT) ? LEN_LONG : LEN_SHORT;
  localparam int AW      = $clog2(LEN_MAX + 1);
  localparam logic [AW-1:0] LAST_S = AW'(LEN_SHORT - 1);
  localparam logic [AW-1:0] LAST_L = AW'(LEN_LONG - 1);

  logic [AW-1:0] ptr_q, last;
  pix_t          wr_d [N_LINES];
  pix_t          rd_d [N_LINES];
  pix_t          top_q, mid_q, bot_q;
  logic          off_q;
  det_t          det;
  pix_t          det_mid;
  logic          det_byp;

  assign last = line_sel_i ? LAST_L : LAST_S;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ptr_q <= '0;
    else if (ce_i) ptr_q <= (ptr_q >= last) ? '0 : ptr_q + 1'b1;
  end

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    if (g == 0) begin : g_head
      assign wr_d[g] = luma_i;
    end else begin : g_chain
      assign wr_d[g] = rd_d[g-1];
    end
    vle_line_mem #(.DEPTH(LEN_MAX), .W(PIX_W), .AW(AW)) mem_i (
      .clk_i  (clk_i),
      .we_i   (ce_i),
      .addr_i (ptr_q),
      .wdata_i(wr_d[g]),
      .rdata_o(rd_d[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      top_q <= '0;
      mid_q <= '0;
      bot_q <= '0;
      off_q <= 1'b0;
    end else if (ce_i) begin
      top_q <= luma_i;
      mid_q <= rd_d[0];
      bot_q <= rd_d[N_LINES-1];
      off_q <= enh_off_i;
    end
  end

  vle_detail #(.SYNC_TH(SYNC_TH)) detail_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ce_i  (ce_i),
    .top_i (top_q),
    .mid_i (mid_q),
    .bot_i (bot_q),
    .core_i(core_lvl_i),
    .off_i (off_q),
    .det_o (det),
    .mid_o (det_mid),
    .byp_o (det_byp)
  );

  vle_gain gain_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ce_i   (ce_i),
    .det_i  (det),
    .mid_i  (det_mid),
    .byp_i  (det_byp),
    .white_i(white_lvl_i),
    .black_i(black_lvl_i),
    .luma_o (luma_o)
  );

  AST_PTR_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q < AW'(LEN_MAX)); // R1
  AST_RESET_ZERO: assert property (@(posedge clk_i)
    !rst_ni |-> (luma_o == '0)); // R10
endmodule

// File: tb/vert_luma_enh_tb.sv
module vert_luma_enh_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int L_S = 4;
  localparam int L_L = 7;

  typedef struct packed {
    logic [7:0] top;
    logic [7:0] mid;
    logic [7:0] bot;
    logic [3:0] core;
    logic [3:0] white;
    logic [3:0] black;
    logic       off;
    logic [7:0] exp;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{8'd100, 8'd100, 8'd100, 4'd6, 4'd10, 4'd11, 1'b0, 8'd100}, // R1 flat
    '{8'd60,  8'd100, 8'd60,  4'd6, 4'd10, 4'd11, 1'b0, 8'd125}, // R3
    '{8'd140, 8'd100, 8'd140, 4'd6, 4'd10, 4'd11, 1'b0, 8'd72 }, // R4
    '{8'd90,  8'd100, 8'd90,  4'd6, 4'd10, 4'd11, 1'b0, 8'd100}, // R2 cored
    '{8'd90,  8'd100, 8'd90,  4'd5, 4'd10, 4'd11, 1'b0, 8'd106}, // R2 at slice
    '{8'd0,   8'd240, 8'd0,   4'd6, 4'd15, 4'd15, 1'b0, 8'd255}, // R5 high
    '{8'd255, 8'd20,  8'd255, 4'd6, 4'd15, 4'd15, 1'b0, 8'd0  }, // R5 low
    '{8'd60,  8'd100, 8'd60,  4'd6, 4'd10, 4'd11, 1'b1, 8'd100}, // R6
    '{8'd60,  8'd10,  8'd60,  4'd6, 4'd10, 4'd11, 1'b0, 8'd10 }, // R7
    '{8'd60,  8'd100, 8'd60,  4'd6, 4'd0,  4'd11, 1'b0, 8'd100}, // R3 zero gain
    '{8'd60,  8'd100, 8'd60,  4'd6, 4'd4,  4'd15, 1'b0, 8'd110}, // R3 white only
    '{8'd140, 8'd100, 8'd140, 4'd6, 4'd15, 4'd4,  1'b0, 8'd90 }, // R4 black only
    '{8'd98,  8'd100, 8'd98,  4'd0, 4'd10, 4'd11, 1'b0, 8'd101}, // R2 no slice
    '{8'd80,  8'd100, 8'd40,  4'd6, 4'd10, 4'd11, 1'b0, 8'd125}, // R1 uneven
    '{8'd0,   8'd16,  8'd0,   4'd6, 4'd10, 4'd11, 1'b0, 8'd26 }, // R7 at threshold
    '{8'd0,   8'd15,  8'd0,   4'd6, 4'd10, 4'd11, 1'b0, 8'd15 }  // R7 below
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ce = 1'b1;
  logic       line_sel = 1'b0;
  logic [7:0] luma_in = '0;
  logic       enh_off = 1'b0;
  logic [3:0] core_lvl = 4'd6;
  logic [3:0] white_lvl = 4'd10;
  logic [3:0] black_lvl = 4'd11;
  logic [7:0] luma_out;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vert_luma_enh #(.LEN_SHORT(L_S), .LEN_LONG(L_L), .SYNC_TH(16)) dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .ce_i       (ce),
    .line_sel_i (line_sel),
    .luma_i     (luma_in),
    .enh_off_i  (enh_off),
    .core_lvl_i (core_lvl),
    .white_lvl_i(white_lvl),
    .black_lvl_i(black_lvl),
    .luma_o     (luma_out)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] v);
    @(negedge clk);
    luma_in = v;
    @(posedge clk);
  endtask

  // three flat lines, then 3 flush samples; ends at the negedge where the result shows
  task automatic run_lines(input logic [7:0] t, input logic [7:0] m, input logic [7:0] b,
                           input int len);
    repeat (len) push(b);
    repeat (len) push(m);
    repeat (len) push(t);
    repeat (3) push(t);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(luma_out, 8'd0, "R10 reset");
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      core_lvl  = VECS[i].core;
      white_lvl = VECS[i].white;
      black_lvl = VECS[i].black;
      enh_off   = VECS[i].off;
      run_lines(VECS[i].top, VECS[i].mid, VECS[i].bot, L_S);
      check(luma_out, VECS[i].exp, $sformatf("vector %0d (R1..R7)", i));
    end
    core_lvl = 4'd6; white_lvl = 4'd10; black_lvl = 4'd11; enh_off = 1'b0;

    // R8: enable switch lands on the 4th edge, same latency as bypass
    repeat (L_S) push(8'd60);
    repeat (L_S) push(8'd100);
    repeat (L_S-1) push(8'd60);
    @(negedge clk);
    luma_in = 8'd60;
    enh_off = 1'b1;
    @(posedge clk);
    push(8'd60);
    push(8'd60);
    @(negedge clk);
    check(luma_out, 8'd125, "R8 before switch");
    @(posedge clk);
    @(negedge clk);
    check(luma_out, 8'd100, "R8 after switch");
    enh_off = 1'b0;

    // R9: clock enable low freezes the output and ignores input
    run_lines(8'd60, 8'd100, 8'd60, L_S);
    ce = 1'b0;
    luma_in = 8'd0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(luma_out, 8'd125, "R9 hold");
    ce = 1'b1;

    // R1: long line selection
    line_sel = 1'b1;
    run_lines(8'd60, 8'd100, 8'd60, L_L);
    check(luma_out, 8'd125, "R1 long line");
    run_lines(8'd140, 8'd100, 8'd140, L_L);
    check(luma_out, 8'd72, "R1 long line black");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule